// File: doc/BRIEF.md
# ALU Status Flag Generator

This block is the arithmetic-logic slice of a small processor core, together with its flag register. It takes two operands and a 2-bit operation select. It computes a result combinationally and, on a valid cycle, folds five status flags into a register. The five flags are carry, zero, negative, overflow and sign. The supported operations are subtract, compare, exclusive-OR and one's complement. Each operation touches only its own subset of flags. The carry flag acts as a borrow after subtraction, and one's complement always forces carry high.

The surrounding core feeds operands from its register file. It writes `result_o` back when `wr_en_o` is high. It uses `lower_o` as the "unsigned lower" branch condition after a compare.

Top module: `alu_flag_unit`

## Requirements
- R1: With op_i = 3 (one's complement), result_o equals the bitwise inverse of opa_i (all-ones minus opa_i), and the registered carry flag (flags_o bit 0) becomes 1 for every operand value.
- R2: After a one's complement, the negative flag (flags_o bit 2) equals result bit 7, the overflow flag (bit 3) is 0, and the sign flag (bit 4) equals negative XOR overflow.
- R3: With op_i = 0 (subtract), result_o equals opa_i - opb_i modulo 256, and carry becomes 1 exactly when opa_i is unsigned-smaller than opb_i (a borrow, the inverse of the adder carry-out).
- R4: After subtract or compare, overflow is 1 exactly when the operand signs differ and the result sign differs from opa_i. Negative is result bit 7, and sign equals negative XOR overflow.
- R5: With op_i = 1 (compare), all flags update exactly as for subtract and wr_en_o stays 0. For the other operations wr_en_o equals valid_i.
- R6: With op_i = 2 (exclusive-OR), result_o equals opa_i XOR opb_i, carry keeps its previous value, overflow is cleared, negative is result bit 7, and sign equals negative.
- R7: The zero flag (flags_o bit 1) becomes 1 exactly when the 8-bit result is zero, for all four operations.
- R8: Flags change only on a rising clock edge with valid_i high. With valid_i low they hold, and wr_en_o is 0.
- R9: While rst_ni is low, all five flags are 0.
- R10: lower_o equals the registered carry flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation valid this cycle |
| op_i | input | 2 | 0 subtract, 1 compare, 2 exclusive-OR, 3 one's complement |
| opa_i | input | 8 | First (destination) operand |
| opb_i | input | 8 | Second operand |
| result_o | output | 8 | Combinational result |
| wr_en_o | output | 1 | Write result back to the destination |
| flags_o | output | 5 | Status flags {S,V,N,Z,C}, C in bit 0 |
| lower_o | output | 1 | Branch condition "unsigned lower" |

## Verification
One's complement is swept over all 256 operands. This shows that carry is forced rather than derived from the subtraction 0xFF - a, which would leave it at 0.

Subtract and compare are swept over every first operand against sixteen second operands. The second operands include 0x00, 0x7F, 0x80 and 0xFF, so the sweep separates a borrow from a carry-out and catches sign-overflow mistakes at both sign boundaries. It also hits the zero result when the operands are equal.

Each exclusive-OR vector is preceded by a subtract chosen to leave carry alternately 0 and 1. A design that touches carry on exclusive-OR therefore shows a mismatch. A final run with valid low after a carry-setting operation shows whether the register holds.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef enum logic [1:0] {
    OP_SUB = 2'd0,
    OP_CMP = 2'd1,
    OP_XOR = 2'd2,
    OP_COM = 2'd3
  } alu_op_e;

  localparam int unsigned NFLAG = 5;
  localparam int unsigned F_C = 0;
  localparam int unsigned F_Z = 1;
  localparam int unsigned F_N = 2;
  localparam int unsigned F_V = 3;
  localparam int unsigned F_S = 4;
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath #(
  parameter int unsigned WIDTH = 8
) (
  input  alu_flag_pkg::alu_op_e op_i,
  input  logic [WIDTH-1:0]      opa_i,
  input  logic [WIDTH-1:0]      opb_i,
  output logic [WIDTH-1:0]      result_o,
  output logic                  borrow_o,
  output logic                  sub_ovf_o
);
  import alu_flag_pkg::*;
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0] diff;

  always_comb begin
    diff      = {1'b0, opa_i} - {1'b0, opb_i};
    borrow_o  = diff[WIDTH];
    sub_ovf_o = (opa_i[MSB] ^ opb_i[MSB]) & (diff[MSB] ^ opa_i[MSB]);
    unique case (op_i)
      OP_SUB, OP_CMP: result_o = diff[MSB:0];
      OP_XOR:         result_o = opa_i ^ opb_i;
      default:        result_o = ~opa_i;
    endcase
  end
endmodule

// File: rtl/alu_flag_rules.sv
module alu_flag_rules #(
  parameter int unsigned WIDTH = 8
) (
  input  alu_flag_pkg::alu_op_e                 op_i,
  input  logic [WIDTH-1:0]                      result_i,
  input  logic                                  borrow_i,
  input  logic                                  sub_ovf_i,
  output logic [alu_flag_pkg::NFLAG-1:0]        new_flags_o,
  output logic [alu_flag_pkg::NFLAG-1:0]        upd_mask_o
);
  import alu_flag_pkg::*;

  logic neg, ovf;

  always_comb begin
    neg = result_i[WIDTH-1];
    ovf = 1'b0;
    new_flags_o = '0;
    upd_mask_o  = '1;
    unique case (op_i)
      OP_SUB, OP_CMP: begin
        ovf = sub_ovf_i;
        new_flags_o[F_C] = borrow_i;
      end
      OP_XOR: begin
        upd_mask_o[F_C] = 1'b0; // carry untouched
      end
      default: begin
        new_flags_o[F_C] = 1'b1; // complement forces carry
      end
    endcase
    new_flags_o[F_Z] = (result_i == '0);
    new_flags_o[F_N] = neg;
    new_flags_o[F_V] = ovf;
    new_flags_o[F_S] = neg ^ ovf;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int unsigned WIDTH = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           valid_i,
  input  logic [1:0]                     op_i,
  input  logic [WIDTH-1:0]               opa_i,
  input  logic [WIDTH-1:0]               opb_i,
  output logic [WIDTH-1:0]               result_o,
  output logic                           wr_en_o,
  output logic [alu_flag_pkg::NFLAG-1:0] flags_o,
  output logic                           lower_o
);
  import alu_flag_pkg::*;

  alu_op_e          op;
  logic             borrow, sub_ovf;
  logic [NFLAG-1:0] new_flags, upd_mask, flags_q;

  assign op = alu_op_e'(op_i);

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .op_i      (op),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .result_o  (result_o),
    .borrow_o  (borrow),
    .sub_ovf_o (sub_ovf)
  );

  alu_flag_rules #(.WIDTH(WIDTH)) u_rules (
    .op_i        (op),
    .result_i    (result_o),
    .borrow_i    (borrow),
    .sub_ovf_i   (sub_ovf),
    .new_flags_o (new_flags),
    .upd_mask_o  (upd_mask)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      flags_q[i] <= 1'b0;
      else if (valid_i && upd_mask[i])  flags_q[i] <= new_flags[i];
    end
  end

  assign wr_en_o = valid_i && (op != OP_CMP);
  assign flags_o = flags_q;
  assign lower_o = flags_q[F_C];

  assert_com_carry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_COM) |=> flags_q[F_C]);
  assert_sign_rel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op == OP_SUB || op == OP_CMP)) |=> (flags_q[F_S] == (flags_q[F_N] ^ flags_q[F_V])));
  assert_cmp_nowrite_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_CMP) |-> !wr_en_o);
  assert_xor_keep_c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_XOR) |=> $stable(flags_q[F_C]));
  assert_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (flags_q[F_Z] == ($past(result_o) == '0)));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_q));
endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [1:0] op = 2'd0;
  logic [7:0] opa = '0, opb = '0;
  logic [7:0] result;
  logic       wr_en, lower;
  logic [4:0] flags;

  int n_chk = 0, n_bad = 0;
  logic [4:0] exp_f = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu_flag_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .opa_i(opa), .opb_i(opb), .result_o(result), .wr_en_o(wr_en),
    .flags_o(flags), .lower_o(lower)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h act=%0h exp=%0h", req, op, opa, opb, act, exp);
    end
  endtask

  // op codes: 0 sub, 1 cmp, 2 xor, 3 com; flags {S,V,N,Z,C}
  task automatic apply(logic [1:0] o, logic [7:0] a, logic [7:0] b, logic v);
    logic [7:0] r;
    logic c, n, ov;
    string rt, ft;
    @(negedge clk);
    op = o; opa = a; opb = b; valid = v;
    case (o)
      2'd0, 2'd1: begin
        r = a - b; c = (a < b);
        ov = (a[7] != b[7]) && (r[7] != a[7]);
        rt = (o == 2'd0) ? "R3" : "R5"; ft = (o == 2'd0) ? "R4" : "R5";
      end
      2'd2: begin r = a ^ b; c = exp_f[0]; ov = 1'b0; rt = "R6"; ft = "R6"; end
      default: begin r = ~a; c = 1'b1; ov = 1'b0; rt = "R1"; ft = "R2"; end
    endcase
    n = r[7];
    #1;
    check(rt, result, r);
    check(v ? "R5" : "R8", wr_en, v && (o != 2'd1));
    if (v) exp_f = {n ^ ov, ov, n, (r == 8'h00), c};
    @(negedge clk);
    check(v ? (o == 2'd3 ? "R1" : ft) : "R8", {flags[4:2], flags[0]}, {exp_f[4:2], exp_f[0]});
    check("R7", flags[1], exp_f[1]);
    check("R10", lower, exp_f[0]);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R9", flags, 5'd0);
    check("R9", lower, 1'b0);
    rst_n = 1'b1;
    for (int a = 0; a < 256; a++) apply(2'd3, 8'(a), 8'h5A, 1'b1);
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 16; k++) begin
        logic [7:0] b;
        b = (k == 0) ? 8'h00 : (k == 1) ? 8'h7F : (k == 2) ? 8'h80 : (k == 3) ? 8'hFF : 8'(k * 17 + 3);
        apply(2'd0, 8'(a), b, 1'b1);
        apply(2'd1, 8'(b), 8'(a), 1'b1);
      end
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 8; k++) begin
        apply(2'd0, 8'(k[0]), 8'(~k[0]), 1'b1);
        apply(2'd2, 8'(a), 8'(k * 37), 1'b1);
      end
    apply(2'd2, 8'hA5, 8'hA5, 1'b1);
    apply(2'd3, 8'h00, 8'h00, 1'b1);
    for (int i = 0; i < 4; i++) apply(2'(i), 8'h00, 8'h01, 1'b0);
    apply(2'd3, 8'hFF, 8'h00, 1'b1);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule